// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire (I2C) bus that fronts a byte-wide internal memory array. Its depth is set by a parameter. A master addresses the block with a select byte, then sends a two-byte memory address with the most significant byte first. It can then write one byte or a burst of bytes within one page. It can also read from the current address, read from a freshly loaded address, or stream bytes sequentially. The block pulls SDA low through an open-drain enable for acknowledges and for read data. It never stretches the clock.

Both bus lines are brought into a system clock domain that is much faster than SCL, through synchronizers. A protocol state machine decodes START, repeated START and STOP, shifts bits in and out, and runs the internal address counter. Write data collects in a one-page staging buffer. The buffer is copied into the array after the master's STOP. This models the non-volatile programming step as an immediate commit. A write-control input turns the block read-only for data bytes but leaves the addressing phase intact.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte is acknowledged only when its upper four bits are 1010 and the next three bits equal `chip_sel_i`; bit 0 is the direction (0 write, 1 read). On a mismatch the block gives no acknowledge and ignores every following byte until the next START.
- R2: The memory address arrives as two acknowledged bytes, high byte first. Only the low log2(MEM_DEPTH) bits are used, and the upper bits are ignored, so addresses that differ only there reach the same byte.
- R3: A write of one data byte followed by STOP stores that byte, and a later read at that address returns it.
- R4: In a write burst, the low log2(PAGE_BYTES) address bits advance after each accepted byte and wrap inside the current page, and the upper address bits never change.
- R5: Staged bytes reach the array only after a STOP, and only for data bytes that were received in full. A START discards any bytes staged since the previous START.
- R6: A read that is not preceded by an address phase returns the byte at the internal counter, which points one past the last byte written or read.
- R7: During a read the counter advances by one after each byte sent and wraps from MEM_DEPTH-1 to 0. The block keeps sending bytes while the master acknowledges.
- R8: A master NACK after a read byte ends the read and leaves SDA released. A STOP always releases SDA on the next clock.
- R9: While `wc_i` is high, the select and address bytes are still acknowledged, every data byte gets no acknowledge, and the array is unchanged. The address counter holds the loaded address.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen after the synchronizers. After reset SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| wc_i | input | 1 | Write control: 1 blocks data writes |
| chip_sel_i | input | 3 | Chip address compared against select bits 3..1 |

## Verification
The bench builds the block with MEM_DEPTH = 2048 and PAGE_BYTES = 64. That gives 11 used address bits and 5 ignored high bits, so aliasing of high addresses can be seen. The wrap from 0x7FF to 0x000 also lies within a short sequential read. The 64-byte page puts the page-edge wrap at offset 63, and a burst that starts at offset 60 crosses it. Random writes and reads are compared against a bench memory model, together with directed cases for a mismatched select, write control, partial bytes and a repeated START.

// File: rtl/i2c_eeprom_pkg.sv
// Shared constants and the protocol state encoding of the serial EEPROM slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_eeprom_pkg;

    // Fixed device-type code carried in select bits 7..4
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol states: receive phases, acknowledge slots, transmit and idle
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_WDATA,
        ST_ACK_WR,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } bus_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
// Brings SCL and SDA into the system clock domain and derives bus events.
// Assumes: the system clock is at least eight times faster than SCL, so every
// SCL level lasts several samples. The lines idle high, and reset values match.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchronizer chains and one-sample history of the synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Edge and condition decode on synchronized samples
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_eeprom_fsm.sv
// Protocol engine: select decode, two-byte address capture, write staging
// strobes, read shifting and the internal address counter.
// Assumes: ADDR_W is between 9 and 16 and PAGE_BYTES is a power of two below
// the array size. SDA changes are made only on SCL falling edges.
module i2c_eeprom_fsm
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int HI_KEEP   = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              wc_i,
    input  logic [2:0]        chip_sel_i,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] addr_cnt,
    output logic              buf_we,
    output logic [PG_W-1:0]   buf_idx,
    output logic [ADDR_W-PG_W-1:0] buf_base,
    output logic [7:0]        buf_data,
    output logic              tx_load,
    output bus_state_t        state
);
    logic [3:0]         bit_cnt;
    logic [7:0]         rx_sh;
    logic [7:0]         tx_sh;
    logic [HI_KEEP-1:0] addr_hi;
    logic               is_read;
    logic               master_nack;
    logic               byte_done;
    logic               sel_ok;

    // Byte-complete event, select match, staging strobe and read-load strobe
    always_comb begin
        byte_done = scl_fall && (bit_cnt == 4'd8);
        sel_ok    = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:1] == chip_sel_i);
        buf_we    = (state == ST_WDATA) && byte_done && !wc_i;
        tx_load   = scl_fall && (((state == ST_ACK_DEV) && is_read) ||
                                 ((state == ST_RACK) && !master_nack));
    end

    assign buf_idx  = addr_cnt[PG_W-1:0];
    assign buf_base = addr_cnt[ADDR_W-1:PG_W];
    assign buf_data = rx_sh;

    // Main protocol sequencing; STOP and START take priority over all phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            addr_hi     <= '0;
            addr_cnt    <= '0;
            is_read     <= 1'b0;
            master_nack <= 1'b0;
            sda_oe      <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEVSEL;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (tx_load) begin
            tx_sh    <= rd_data;
            sda_oe   <= ~rd_data[7];
            addr_cnt <= addr_cnt + 1'b1;
            bit_cnt  <= '0;
            state    <= ST_RDATA;
        end else begin
            case (state)
                ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    if (scl_rise && (bit_cnt != 4'd8)) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        case (state)
                            ST_DEVSEL: begin
                                if (sel_ok) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= rx_sh[0];
                                    state   <= ST_ACK_DEV;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end
                            ST_ADDR_HI: begin
                                addr_hi <= rx_sh[HI_KEEP-1:0];
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_HI;
                            end
                            ST_ADDR_LO: begin
                                addr_cnt <= {addr_hi, rx_sh};
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK_LO;
                            end
                            default: begin
                                sda_oe <= !wc_i;
                                if (!wc_i) begin
                                    addr_cnt <= {addr_cnt[ADDR_W-1:PG_W],
                                                 addr_cnt[PG_W-1:0] + 1'b1};
                                end
                                state <= ST_ACK_WR;
                            end
                        endcase
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_ADDR_HI;
                    end
                end
                ST_ACK_HI: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_ADDR_LO;
                    end
                end
                ST_ACK_LO, ST_ACK_WR: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && (bit_cnt != 4'd8)) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        master_nack <= sda_s;
                    end
                    if (scl_fall) begin
                        state <= ST_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_page_buffer.sv
// One-page staging buffer with per-byte valid flags. After a commit request
// it walks the page once and writes each valid byte into the array.
// Assumes: the bus idle time between STOP and the next START is longer than
// PAGE_BYTES system clocks, so no staging write meets a running commit.
module i2c_page_buffer #(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 64,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PG_W-1:0]        wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [ADDR_W-PG_W-1:0] wr_base,
    input  logic                   clear,
    input  logic                   commit_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_waddr,
    output logic [7:0]             mem_wdata,
    output logic                   busy
);
    logic [7:0]             page_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]  valid;
    logic [ADDR_W-PG_W-1:0] base;
    logic [PG_W-1:0]        scan;

    // Data storage of staged bytes; contents need no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            page_data[wr_idx] <= wr_data;
        end
    end

    // Valid flags, page base and the commit walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            base  <= '0;
            scan  <= '0;
            busy  <= 1'b0;
        end else if (busy) begin
            valid[scan] <= 1'b0;
            scan        <= scan + 1'b1;
            if (scan == PG_W'(PAGE_BYTES - 1)) begin
                busy <= 1'b0;
            end
        end else if (commit_req) begin
            if (|valid) begin
                busy <= 1'b1;
                scan <= '0;
            end
        end else if (clear) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
            base          <= wr_base;
        end
    end

    // Array write port driven during the walk
    always_comb begin
        mem_we    = busy && valid[scan];
        mem_waddr = {base, scan};
        mem_wdata = page_data[scan];
    end

endmodule

// File: rtl/i2c_mem_array.sv
// Byte-wide storage array: one synchronous write port and one combinational
// read port. Assumes DEPTH = 2**ADDR_W.
module i2c_mem_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Committed writes from the staging buffer
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
// Top level of the serial EEPROM slave: synchronizer, protocol engine, page
// staging buffer and storage array. Assumes MEM_DEPTH is a power of two
// between 512 and 65536, PAGE_BYTES is a power of two below MEM_DEPTH, and
// SDA is an open-drain line driven low when sda_oe_o is 1.
module i2c_eeprom_slave #(
    parameter int MEM_DEPTH   = 2048,
    parameter int PAGE_BYTES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wc_i,
    input  logic [2:0] chip_sel_i
);
    import i2c_eeprom_pkg::*;

    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int PG_W   = $clog2(PAGE_BYTES);

    logic                   sda_s;
    logic                   scl_rise;
    logic                   scl_fall;
    logic                   start_det;
    logic                   stop_det;
    logic [7:0]             rd_data;
    logic [ADDR_W-1:0]      addr_cnt;
    logic                   buf_we;
    logic [PG_W-1:0]        buf_idx;
    logic [ADDR_W-PG_W-1:0] buf_base;
    logic [7:0]             buf_data;
    logic                   tx_load;
    bus_state_t             fsm_state;
    logic                   mem_we;
    logic [ADDR_W-1:0]      mem_waddr;
    logic [7:0]             mem_wdata;
    logic                   buf_busy;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_eeprom_fsm #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_s      (sda_s),
        .wc_i       (wc_i),
        .chip_sel_i (chip_sel_i),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe_o),
        .addr_cnt   (addr_cnt),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .buf_base   (buf_base),
        .buf_data   (buf_data),
        .tx_load    (tx_load),
        .state      (fsm_state)
    );

    i2c_page_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (buf_we),
        .wr_idx     (buf_idx),
        .wr_data    (buf_data),
        .wr_base    (buf_base),
        .clear      (start_det),
        .commit_req (stop_det),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .busy       (buf_busy)
    );

    i2c_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_cnt),
        .rdata (rd_data)
    );

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
// Protocol checker for the EEPROM slave, attached to the top by bind.
// Assumes the bound signals come from the top's internal nets.
module i2c_eeprom_slave_chk
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PG_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_det,
    input logic              stop_det,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              sda_oe,
    input bus_state_t        state,
    input logic              wc_i,
    input logic              buf_we,
    input logic              buf_busy,
    input logic              tx_load,
    input logic [ADDR_W-1:0] addr_cnt
);

    // R10: bus events from the synchronizer never coincide
    a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det, scl_rise, scl_fall}));

    // R8: a STOP releases SDA on the next clock
    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R8: SDA is free while the master answers a read byte
    a_r8_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_oe);

    // R1: an unselected or idle slave never pulls SDA
    a_r1_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) || (state == ST_IDLE)) |-> !sda_oe);

    // R9: no byte is staged while write control is high
    a_r9_wc_blocks_stage: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !wc_i);

    // R5: an array commit starts only right after a STOP
    a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_busy) |-> $past(stop_det));

    // R7: each byte loaded for transmit advances the counter by one, wrapping
    a_r7_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (addr_cnt == ADDR_W'($past(addr_cnt) + 1'b1)));

    // R4: a staged write keeps the counter inside the same page
    a_r4_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (addr_cnt[ADDR_W-1:PG_W] == $past(addr_cnt[ADDR_W-1:PG_W])));

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_oe    (sda_oe_o),
    .state     (fsm_state),
    .wc_i      (wc_i),
    .buf_we    (buf_we),
    .buf_busy  (buf_busy),
    .tx_load   (tx_load),
    .addr_cnt  (addr_cnt)
);

// File: tb/i2c_eeprom_slave_tb.sv
// Self-checking bench: bus-level master tasks plus a bench memory model.
module i2c_eeprom_slave_tb;
    localparam int DEPTH = 2048;
    localparam int PAGE  = 64;
    localparam int AMASK = DEPTH - 1;
    localparam int Q     = 8;
    localparam logic [2:0] CHIP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, CHIP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, CHIP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wc = 1'b0;
    logic sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [DEPTH];
    bit         known [DEPTH];
    int         ptr = 0;
    logic [7:0] wbuf [PAGE];

    always #4 clk = ~clk;

    i2c_eeprom_slave #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .wc_i       (wc),
        .chip_sel_i (CHIP)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_restart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
        tick(90);
    endtask

    task automatic clock_bit(input bit b, output bit s);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!mack, s);
    endtask

    // Addressing phase: select plus two address bytes, all must be acknowledged
    task automatic send_addr(input int a, input string req);
        bit ack;
        send_byte(DEV_W, ack);      chk(ack, {req, " select ack (R1)"}, ack, 1);
        send_byte(a[15:8], ack);    chk(ack, {req, " addr hi ack (R2)"}, ack, 1);
        send_byte(a[7:0], ack);     chk(ack, {req, " addr lo ack (R2)"}, ack, 1);
    endtask

    // Write burst of n bytes from wbuf; model follows the page wrap rule (R4)
    task automatic write_txn(input int a, input int n, input bit wcv, input string req);
        bit ack;
        int base;
        wc = wcv;
        bus_start();
        send_addr(a, req);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack == !wcv, wcv ? "R9 data nack" : {req, " data ack"}, ack, !wcv);
        end
        bus_stop();
        wc = 1'b0;
        base = a & AMASK & ~(PAGE - 1);
        if (wcv) begin
            ptr = a & AMASK;
        end else begin
            for (int i = 0; i < n; i++) begin
                int ad;
                ad = base | ((a + i) & (PAGE - 1));
                ref_mem[ad] = wbuf[i];
                known[ad] = 1'b1;
            end
            ptr = base | ((a + n) & (PAGE - 1));
        end
    endtask

    // Read n bytes from the current pointer, NACK on the last, then check release (R8)
    task automatic read_body(input int n, input string req);
        logic [7:0] b;
        bit ack;
        send_byte(DEV_R, ack);
        chk(ack, {req, " read select ack (R1)"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            if (known[ptr]) chk(b == ref_mem[ptr], req, b, ref_mem[ptr]);
            ptr = (ptr + 1) & AMASK;
        end
        tick(Q);
        chk(sda_oe == 1'b0, "R8 released after master nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic read_random(input int a, input int n, input string req);
        bit ack;
        bus_start();
        send_addr(a, req);
        bus_restart();
        ptr = a & AMASK;
        read_body(n, req);
    endtask

    task automatic read_current(input int n, input string req);
        bus_start();
        read_body(n, req);
    endtask

    initial begin
        repeat (189000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit s;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R10: SDA released after reset
        chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);

        // R3: single byte write then random read
        wbuf[0] = 8'h3C;
        write_txn(16'h0010, 1, 1'b0, "R3");
        read_random(16'h0010, 1, "R3 byte readback");
        wbuf[0] = 8'hC7;
        write_txn(16'h0020, 1, 1'b0, "R3");

        // R2: high address bits ignored (0xF805 aliases 0x005)
        wbuf[0] = 8'h96;
        write_txn(16'hF805, 1, 1'b0, "R2");
        read_random(16'h0005, 1, "R2 alias readback");

        // R4: burst starting at page offset 60 wraps inside the page
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h50 + i);
        write_txn(16'h007C, 10, 1'b0, "R4");
        read_random(16'h0040, 6, "R4 wrapped bytes");
        // R6: current-address read continues where the last read stopped
        read_random(16'h007C, 2, "R4 page tail");
        read_current(2, "R6 current read");

        // R7: sequential read wraps from the top of the array to 0
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        write_txn(16'h07FE, 2, 1'b0, "R7");
        wbuf[0] = 8'hB1; wbuf[1] = 8'hB2;
        write_txn(16'h0000, 2, 1'b0, "R7");
        read_random(16'h07FE, 4, "R7 rollover read");

        // R9: write control blocks data, address still acknowledged
        wbuf[0] = 8'h00;
        write_txn(16'h0010, 1, 1'b1, "R9");
        read_random(16'h0010, 1, "R9 memory unchanged");

        // R1: wrong chip bits, no ack and later bytes ignored
        bus_start();
        send_byte(8'hA0, ack); chk(!ack, "R1 mismatch nack", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R1 ignored byte", ack, 0);
        send_byte(8'h10, ack); chk(!ack, "R1 ignored byte", ack, 0);
        send_byte(8'hFF, ack); chk(!ack, "R1 ignored byte", ack, 0);
        bus_stop();
        read_random(16'h0010, 1, "R1 memory unchanged");

        // R5: partial data byte before STOP is not stored
        bus_start();
        send_addr(16'h0020, "R5");
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_stop();
        ptr = 16'h0020;
        read_random(16'h0020, 1, "R5 partial byte dropped");

        // R5: repeated START discards a staged byte
        bus_start();
        send_addr(16'h0020, "R5");
        send_byte(8'h5A, ack); chk(ack, "R5 staged byte ack", ack, 1);
        bus_restart();
        send_addr(16'h0020, "R5");
        bus_stop();
        read_random(16'h0020, 1, "R5 restart discard");

        // Random mix of writes and reads against the model
        for (int t = 0; t < 16; t++) begin
            int a;
            int n;
            a = $urandom_range(0, 16'hFFFF);
            if ($urandom_range(0, 1) == 0) begin
                n = $urandom_range(1, 8);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                write_txn(a, n, ($urandom_range(0, 9) == 0), "R4 random write");
            end else if ($urandom_range(0, 1) == 0) begin
                read_random(a, $urandom_range(1, 6), "R7 random read");
            end else begin
                read_current($urandom_range(1, 4), "R6 random current read");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule